// File: doc/BRIEF.md
# One-Dimensional Texel Fetch and Filter Unit

This block takes a one-dimensional texture coordinate and turns it into one or two reads of a small on-chip texel store. It returns a fixed-point result. The coordinate is either an integer texel index or an unsigned Q0.16 fraction that spans the full texture width.

A set of mode inputs is sampled together with each request. They choose:
- normalized or integer coordinates;
- nearest-texel or two-texel linear filtering;
- edge clamping or modulo wrapping for out-of-range indices;
- whether the 8-bit unsigned texel comes back as a plain integer or as a Q1.8 fraction.

A separate raw mode overrides all of these and fetches the texel at the integer index directly.

Requests arrive on a valid/ready channel and results leave on a valid/ready channel. The unit keeps one fetch in flight, so results come back in request order. The texel store sits outside the block. It is reached through a read-enable/address port whose data comes back on the cycle after the enable. The unit only reads. It does nothing to order itself against writes to the store while a fetch is in progress.

Top module: `tex_fetch_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: With `cfg_raw` set, the texel at index `req_coord mod N` is read once and returned zero-extended as {1'b0, texel}, whatever the other mode inputs are.
- R3: In integer point mode with clamping, the read index is `req_coord`, limited to N-1.
- R4: With wrapping, every index the unit computes is reduced modulo N, and that includes an index of -1, which becomes N-1.
- R5: In normalized point mode, the read index is floor(req_coord * N / 65536).
- R6: In normalized linear mode, the position p = floor(req_coord * N / 256) - 128 is in units of 1/256 texel. The unit reads texels i0 = floor(p/256) and i1 = i0+1, each placed by the address mode (clamping sends negative indices to 0). With weight w = p mod 256, the result is floor((t0*(256-w) + t1*w)/256).
- R7: In integer linear mode, the weight is 0. Two reads are still made, and the result equals the texel at the placed index `req_coord`.
- R8: A point fetch makes exactly one read. A linear fetch makes exactly two reads on consecutive cycles, i0 first.
- R9: With `cfg_norm_read` set (and raw mode off), the filtered 8-bit value v is returned as the Q1.8 value v + (v >> 7). So 0 gives 0, 255 gives 256 (1.0), and the result never exceeds 256. With it clear, the value is returned as {1'b0, v}.
- R10: `req_ready` is high only when no fetch is in flight. `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is seen, and `rsp_valid` drops on the cycle after that handshake.
- R11: The texel store returns `mem_rdata` for `mem_addr` on the cycle after `mem_rd_en`, and the unit samples it in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_norm_coord | input | 1 | Coordinate is Q0.16 normalized when 1 |
| cfg_linear | input | 1 | Linear filtering when 1, nearest when 0 |
| cfg_wrap | input | 1 | Wrap addressing when 1, clamp when 0 |
| cfg_norm_read | input | 1 | Return Q1.8 fraction when 1 |
| cfg_raw | input | 1 | Raw direct-index mode, overrides the others |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_coord | input | COORD_W | Texture coordinate |
| mem_rd_en | output | 1 | Texel store read enable |
| mem_addr | output | TEX_LOG2 | Texel store address |
| mem_rdata | input | TEXEL_W | Texel data, one cycle after the read |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumed when high with rsp_valid |
| rsp_data | output | TEXEL_W+1 | Filtered result |

## Verification
The assertions rely on two things about the inputs. First, the texel store answers exactly one cycle after `mem_rd_en`; without that, the bounded-blend and read-count properties would be comparing stale data. Second, the consumer can stall `rsp_ready` for any length of time; the hold properties depend on that. The bench models the store as a registered array and changes its contents only between fetches. It drives the mode inputs only alongside a request. It stalls the response for random spans of zero to two cycles. The random coordinates are mixed so that integer mode often lands just inside and just outside the texture width.

// File: rtl/tex_pkg.sv
package tex_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_CAP,
    ST_RSP
  } tex_state_e;

  typedef struct packed {
    logic norm_coord;
    logic linear;
    logic wrap;
    logic norm_read;
    logic raw;
  } tex_cfg_t;

endpackage

// File: rtl/tex_addr_gen.sv
module tex_addr_gen
  import tex_pkg::*;
#(
  parameter int COORD_W  = 16,
  parameter int TEX_LOG2 = 4,
  parameter int FRAC_W   = 8,
  parameter int POS_W    = 26,
  localparam int IDX_W   = POS_W - FRAC_W
) (
  input  logic [COORD_W-1:0]       coord,
  input  tex_cfg_t                 cfg,
  output logic signed [IDX_W-1:0]  idx0,
  output logic signed [IDX_W-1:0]  idx1,
  output logic [FRAC_W-1:0]        weight,
  output logic                     two_reads
);

  localparam logic [POS_W-1:0] HALF = POS_W'(1) << (FRAC_W - 1);

  logic [POS_W-1:0] scaled;
  logic [POS_W-1:0] pos;
  logic             use_norm;
  logic             use_lin;

  always_comb begin
    use_norm = cfg.norm_coord & ~cfg.raw;
    use_lin  = cfg.linear & ~cfg.raw;
    scaled   = POS_W'(coord) << TEX_LOG2;
    if (use_norm) begin
      pos = scaled >> (COORD_W - FRAC_W);
      if (use_lin) pos = pos - HALF;
    end else begin
      pos = POS_W'(coord) << FRAC_W;
    end
    idx0      = signed'(pos[POS_W-1:FRAC_W]);
    idx1      = idx0 + IDX_W'(1);
    weight    = (use_lin && use_norm) ? pos[FRAC_W-1:0] : '0;
    two_reads = use_lin;
  end

endmodule

// File: rtl/tex_edge_map.sv
module tex_edge_map #(
  parameter int IDX_W    = 18,
  parameter int TEX_LOG2 = 4
) (
  input  logic signed [IDX_W-1:0] idx,
  input  logic                    wrap,
  output logic [TEX_LOG2-1:0]     addr
);

  logic below;
  logic above;

  always_comb begin
    below = idx[IDX_W-1];
    above = ~below & (|idx[IDX_W-2:TEX_LOG2]);
    if (wrap)       addr = idx[TEX_LOG2-1:0];
    else if (below) addr = '0;
    else if (above) addr = '1;
    else            addr = idx[TEX_LOG2-1:0];
  end

endmodule

// File: rtl/tex_filter.sv
module tex_filter #(
  parameter int TEXEL_W = 8,
  parameter int FRAC_W  = 8
) (
  input  logic [TEXEL_W-1:0] t0,
  input  logic [TEXEL_W-1:0] t1,
  input  logic [FRAC_W-1:0]  weight,
  input  logic               norm_read,
  output logic [TEXEL_W:0]   result
);

  localparam int SUM_W = TEXEL_W + FRAC_W + 1;

  logic [FRAC_W:0]    inv_w;
  logic [SUM_W-1:0]   sum;
  logic [TEXEL_W-1:0] blend;

  always_comb begin
    inv_w  = (FRAC_W+1)'(1 << FRAC_W) - (FRAC_W+1)'(weight);
    sum    = SUM_W'(t0) * SUM_W'(inv_w) + SUM_W'(t1) * SUM_W'(weight);
    blend  = TEXEL_W'(sum >> FRAC_W);
    if (norm_read) result = {1'b0, blend} + (TEXEL_W+1)'(blend >> (TEXEL_W - 1));
    else           result = {1'b0, blend};
  end

endmodule

// File: rtl/tex_fetch_unit.sv
module tex_fetch_unit
  import tex_pkg::*;
#(
  parameter int COORD_W  = 16,
  parameter int TEX_LOG2 = 4,
  parameter int TEXEL_W  = 8,
  parameter int FRAC_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_norm_coord,
  input  logic                cfg_linear,
  input  logic                cfg_wrap,
  input  logic                cfg_norm_read,
  input  logic                cfg_raw,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [COORD_W-1:0]  req_coord,
  output logic                mem_rd_en,
  output logic [TEX_LOG2-1:0] mem_addr,
  input  logic [TEXEL_W-1:0]  mem_rdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [TEXEL_W:0]    rsp_data
);

  localparam int SPAN_W = (TEX_LOG2 > FRAC_W) ? TEX_LOG2 : FRAC_W;
  localparam int POS_W  = COORD_W + SPAN_W + 2;
  localparam int IDX_W  = POS_W - FRAC_W;

  tex_state_e state_q, state_d;
  tex_cfg_t   cfg_in;

  logic signed [IDX_W-1:0]  idx_a [2];
  logic [TEX_LOG2-1:0]      map_a [2];
  logic [FRAC_W-1:0]        weight_c;
  logic                     two_c;
  logic                     accept;

  logic [TEX_LOG2-1:0] addr0_q, addr1_q;
  logic [FRAC_W-1:0]   w_q;
  logic                lin_q, nread_q;
  logic [TEXEL_W-1:0]  t0_q, t1_q;
  logic                t0_en, t1_en;

  assign cfg_in = '{norm_coord: cfg_norm_coord, linear: cfg_linear,
                    wrap: cfg_wrap, norm_read: cfg_norm_read, raw: cfg_raw};

  tex_addr_gen #(
    .COORD_W (COORD_W),
    .TEX_LOG2(TEX_LOG2),
    .FRAC_W  (FRAC_W),
    .POS_W   (POS_W)
  ) u_agen (
    .coord    (req_coord),
    .cfg      (cfg_in),
    .idx0     (idx_a[0]),
    .idx1     (idx_a[1]),
    .weight   (weight_c),
    .two_reads(two_c)
  );

  for (genvar g = 0; g < 2; g++) begin : g_edge
    tex_edge_map #(
      .IDX_W   (IDX_W),
      .TEX_LOG2(TEX_LOG2)
    ) u_map (
      .idx (idx_a[g]),
      .wrap(cfg_wrap | cfg_raw),
      .addr(map_a[g])
    );
  end

  // control next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_RD0;
      ST_RD0:  state_d = lin_q ? ST_RD1 : ST_CAP;
      ST_RD1:  state_d = ST_CAP;
      ST_CAP:  state_d = ST_RSP;
      ST_RSP:  if (rsp_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign mem_rd_en = (state_q == ST_RD0) | (state_q == ST_RD1);
  assign mem_addr  = (state_q == ST_RD1) ? addr1_q : addr0_q;
  assign t0_en     = (state_q == ST_RD1) | ((state_q == ST_CAP) & ~lin_q);
  assign t1_en     = (state_q == ST_CAP) & lin_q;
  assign rsp_valid = (state_q == ST_RSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr0_q <= '0;
      addr1_q <= '0;
      w_q     <= '0;
      lin_q   <= 1'b0;
      nread_q <= 1'b0;
    end else if (accept) begin
      addr0_q <= map_a[0];
      addr1_q <= map_a[1];
      w_q     <= weight_c;
      lin_q   <= two_c;
      nread_q <= cfg_norm_read & ~cfg_raw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     t0_q <= '0;
    else if (t0_en) t0_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     t1_q <= '0;
    else if (t1_en) t1_q <= mem_rdata;
  end

  tex_filter #(
    .TEXEL_W(TEXEL_W),
    .FRAC_W (FRAC_W)
  ) u_filt (
    .t0       (t0_q),
    .t1       (t1_q),
    .weight   (w_q),
    .norm_read(nread_q),
    .result   (rsp_data)
  );

  // read counter kept only for the checks below
  logic [1:0] rd_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_cnt_q <= '0;
    else if (accept)    rd_cnt_q <= '0;
    else if (mem_rd_en) rd_cnt_q <= rd_cnt_q + 2'd1;
  end

  // R8
  read_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> rd_cnt_q == (lin_q ? 2'd2 : 2'd1));

  // R8
  reads_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && lin_q && rd_cnt_q == 2'd0) |=> mem_rd_en);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R9
  norm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && nread_q) |-> rsp_data <= (TEXEL_W+1)'(1 << TEXEL_W));

  // R6
  blend_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !nread_q) |->
      ((rsp_data >= {1'b0, (t0_q < t1_q) ? t0_q : t1_q}) &&
       (rsp_data <= {1'b0, (t0_q > t1_q) ? t0_q : t1_q})));

endmodule

// File: tb/sim_tex_fetch_unit.sv
module sim_tex_fetch_unit;

  localparam int N = 16;

  logic        clk, rst_n;
  logic        cfg_norm_coord, cfg_linear, cfg_wrap, cfg_norm_read, cfg_raw;
  logic        req_valid, req_ready;
  logic [15:0] req_coord;
  logic        mem_rd_en;
  logic [3:0]  mem_addr;
  logic [7:0]  mem_rdata;
  logic        rsp_valid, rsp_ready;
  logic [8:0]  rsp_data;

  logic [7:0] mem [N];
  int checks, fails, cyc, n_reads, rd_first, rd_last;

  tex_fetch_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_norm_coord(cfg_norm_coord), .cfg_linear(cfg_linear),
    .cfg_wrap(cfg_wrap), .cfg_norm_read(cfg_norm_read), .cfg_raw(cfg_raw),
    .req_valid(req_valid), .req_ready(req_ready), .req_coord(req_coord),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // R11 texel store with one-cycle read latency
  always @(posedge clk) begin
    cyc++;
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr];
      if (n_reads == 0) rd_first = cyc;
      rd_last = cyc;
      n_reads++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int place(input int i, input bit wr);
    if (wr)         return i & (N - 1);
    else if (i < 0) return 0;
    else if (i > N - 1) return N - 1;
    else            return i;
  endfunction

  function automatic int model(input int c, input bit nc, lin, wr, nr, raw);
    int p, i0, w, v;
    if (raw) return mem[c % N];
    if (nc) begin
      p = (c * N) >>> 8;
      if (lin) p = p - 128;
    end else begin
      p = c * 256;
    end
    i0 = p >>> 8;
    w  = (lin && nc) ? (p & 255) : 0;
    v  = (mem[place(i0, wr)] * (256 - w) + mem[place(i0 + 1, wr)] * w) >> 8;
    if (nr) v = v + (v >> 7);
    return v;
  endfunction

  task automatic run_req(input int c, input bit nc, lin, wr, nr, raw, input string tag);
    int e, hold, guard;
    e = model(c, nc, lin, wr, nr, raw);
    @(negedge clk);
    req_coord = 16'(c);
    cfg_norm_coord = nc; cfg_linear = lin; cfg_wrap = wr;
    cfg_norm_read = nr; cfg_raw = raw;
    req_valid = 1'b1;
    n_reads = 0;
    chk("R10", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", int'(req_ready), 0);
    guard = 0;
    while (!rsp_valid && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    chk(tag, int'(rsp_data), e);
    chk("R8", n_reads, (lin && !raw) ? 2 : 1);
    if (lin && !raw) chk("R8", rd_last - rd_first, 1);
    hold = $urandom_range(0, 2);
    repeat (hold) @(negedge clk);
    if (hold > 0) begin
      chk("R10", int'(rsp_valid), 1);
      chk("R10", int'(rsp_data), e);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    checks = 0; fails = 0; cyc = 0; n_reads = 0; rd_first = 0; rd_last = 0;
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0; req_coord = '0;
    cfg_norm_coord = 0; cfg_linear = 0; cfg_wrap = 0; cfg_norm_read = 0; cfg_raw = 0;
    for (int i = 0; i < N; i++) mem[i] = 8'(i * 13 + 7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(req_ready), 1);
    chk("R1", int'(rsp_valid), 0);
    chk("R1", int'(mem_rd_en), 0);

    // directed corners
    run_req(37, 1, 1, 0, 1, 1, "R2");
    run_req(100, 0, 0, 0, 0, 0, "R3");
    run_req(15, 0, 0, 0, 0, 0, "R3");
    run_req(100, 0, 0, 1, 0, 0, "R4");
    run_req(16'h8000, 1, 0, 0, 0, 0, "R5");
    run_req(16'hFFFF, 1, 0, 0, 0, 0, "R5");
    run_req(0, 1, 1, 0, 0, 0, "R6");
    run_req(0, 1, 1, 1, 0, 0, "R4");
    run_req(16'hFFFF, 1, 1, 0, 0, 0, "R6");
    run_req(16'h1234, 1, 1, 1, 0, 0, "R6");
    run_req(9, 0, 1, 0, 0, 0, "R7");
    run_req(16, 0, 1, 1, 0, 0, "R7");
    mem[0] = 8'd255; mem[1] = 8'd0;
    run_req(0, 0, 0, 0, 1, 0, "R9");
    run_req(1, 0, 0, 0, 1, 0, "R9");
    run_req(0, 0, 0, 0, 0, 0, "R9");

    // constrained random
    for (int k = 0; k < 200; k++) begin
      int c;
      bit nc, lin, wr, nr, raw;
      if (k % 25 == 0)
        for (int i = 0; i < N; i++) mem[i] = 8'($urandom_range(0, 255));
      nc  = 1'($urandom);
      lin = 1'($urandom);
      wr  = 1'($urandom);
      nr  = 1'($urandom);
      raw = ($urandom_range(0, 5) == 0);
      c   = (!nc && $urandom_range(0, 1) == 1) ? $urandom_range(0, 40)
                                                : $urandom_range(0, 65535);
      run_req(c, nc, lin, wr, nr, raw, raw ? "R2" : (lin ? (nc ? "R6" : "R7") : (nc ? "R5" : "R3")));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule